// File: doc/BRIEF.md
# Programmable-Frame Serial Transmitter

This block turns bytes offered by an upstream transmit buffer into asynchronous serial frames on a single output line. A frame has a low start bit, then five to eight data bits sent least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. The data width, parity and stop-bit settings come from static configuration inputs. Each bit lasts sixteen periods of an external oversampling tick.

The upstream buffer presents a byte with a valid/ready handshake. The block asks for a new byte only between frames, and only on a tick. A one-cycle break request makes the block hold the line low for one whole frame time, measured with the current settings. The break starts only after the word in flight has gone out. Normal transfers resume after it. When flow control is enabled, the active-low clear-to-send input gates the start of each new word. It never stops a word that is already on the line.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset and whenever no frame or break is in progress, `txd` is high and `busy` is low.
- R2: A data frame is a low start bit followed by the data bits, least significant first. The number of data bits is 5 + `cfg_width` (code 0→5, 1→6, 2→7, 3→8).
- R3: With `cfg_par_en`=1, one parity bit follows the data bits. It is computed over the configured data bits only. `cfg_par_odd`=0 gives even parity (data bits plus parity hold an even number of ones) and 1 gives odd parity. With `cfg_par_en`=0 no parity bit is sent.
- R4: The frame ends with one high stop bit when `cfg_two_stop`=0, and two when it is 1.
- R5: Every bit of a frame or break lasts exactly 16 ticks of `tick16`. `txd` only changes on a clock edge where `tick16` is high.
- R6: `byte_ready` is high only in a cycle where `tick16` is high, the line is idle, no break is pending and flow control allows a start. A byte is taken exactly in a cycle with `byte_valid` and `byte_ready` both high.
- R7: A pulse on `brk_req` holds `txd` low for one frame time (frame length in bits × 16 ticks, from the settings at break start). A break never starts before the current frame has ended, and it takes precedence over the next byte.
- R8: After a break ends, queued bytes are taken and sent as normal frames.
- R9: With `afc_en`=1 and `cts_n`=1, no new byte is taken. Raising `cts_n` during a frame does not shorten that frame.
- R10: `all_sent` is high exactly when no frame or break is in progress, `byte_valid` is low and no break is pending.
- R11: `busy` rises on the clock edge that takes a byte or starts a break. It falls on the edge that ends the last stop bit or the last break bit.
- R12: The settings are captured when a frame starts. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| byte_valid | input | 1 | Upstream buffer has a byte to offer |
| byte_data | input | 8 | Byte offered by the buffer |
| byte_ready | output | 1 | Byte is taken this cycle if valid |
| cfg_width | input | 2 | Data width code, 5 + code bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| brk_req | input | 1 | Break request pulse |
| afc_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Active-low clear to send |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame or break in progress |
| all_sent | output | 1 | Nothing queued, pending or shifting |

## Verification
Suppose the internal state goes wrong: a corrupted remaining-bit count, a bit counter off by one, or a break flag that is lost. That fault shows on `txd` or `busy` no later than the next bit boundary, which is at most 16 ticks away. It shows either as a bit that is too long or too short or as a frame with the wrong length. Because `byte_ready` and `all_sent` depend on the idle state and on the pending break, a stuck pending flag shows on those outputs in the same cycle. The reference model predicts all four outputs on every cycle. The first divergence is reported in the cycle where it occurs.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_MAX  = 8;
    localparam int DATA_MIN  = 5;
    localparam int FRAME_MAX = DATA_MAX + 4;
    localparam int SLOT_W    = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        logic [1:0] width_code;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } tx_cfg_t;

    typedef enum logic [1:0] {
        LAUNCH_NONE  = 2'd0,
        LAUNCH_DATA  = 2'd1,
        LAUNCH_BREAK = 2'd2
    } launch_e;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [SLOT_W-1:0]    len;
    } frame_t;

    function automatic int data_bits(input logic [1:0] code);
        return DATA_MIN + int'(code);
    endfunction

    function automatic logic calc_parity(input logic [DATA_MAX-1:0] d,
                                         input logic [1:0] code,
                                         input logic odd);
        logic p;
        p = odd;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < data_bits(code)) p = p ^ d[i];
        end
        return p;
    endfunction

    function automatic frame_t build_frame(input logic [DATA_MAX-1:0] d,
                                           input tx_cfg_t c,
                                           input logic brk);
        frame_t f;
        int     w;
        int     n;
        logic   par;
        w      = data_bits(c.width_code);
        par    = calc_parity(d, c.width_code, c.par_odd);
        f.bits = '1;
        f.bits[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < w) f.bits[i+1] = d[i];
        end
        for (int i = 0; i < FRAME_MAX; i++) begin
            if (c.par_en && (i == w + 1)) f.bits[i] = par;
        end
        n = 2 + w + int'(c.par_en) + int'(c.two_stop);
        if (brk) f.bits = '0;
        f.len = SLOT_W'(n);
        return f;
    endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic active,
    input  logic load,
    output logic bit_end
);
    localparam int CW = $clog2(TICKS);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt <= '0;
        end else if (active && tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_end = active && tick && (cnt == LAST);
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
    import uart_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t frame_in,
    input  logic   advance,
    output logic   txd,
    output logic   active
);
    logic [FRAME_MAX-1:0] rest;
    logic [SLOT_W-1:0]    left;

    always_ff @(posedge clk) begin
        if (rst) begin
            txd  <= 1'b1;
            rest <= '1;
            left <= '0;
        end else if (load) begin
            txd  <= frame_in.bits[0];
            rest <= {1'b1, frame_in.bits[FRAME_MAX-1:1]};
            left <= frame_in.len;
        end else if (advance) begin
            if (left == SLOT_W'(1)) begin
                txd <= 1'b1;
            end else begin
                txd <= rest[0];
            end
            rest <= {1'b1, rest[FRAME_MAX-1:1]};
            left <= left - 1'b1;
        end
    end

    assign active = (left != '0);
endmodule

// File: rtl/tx_launch_ctrl.sv
module tx_launch_ctrl
    import uart_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    active,
    input  logic    byte_valid,
    input  logic    brk_req,
    input  logic    afc_en,
    input  logic    cts_n,
    output logic    byte_ready,
    output launch_e launch,
    output logic    brk_pend
);
    logic slot_free;
    logic cts_ok;

    assign slot_free  = !active && tick;
    assign cts_ok     = !afc_en || !cts_n;
    assign byte_ready = slot_free && !brk_pend && cts_ok;

    always_comb begin
        if (slot_free && brk_pend) begin
            launch = LAUNCH_BREAK;
        end else if (byte_ready && byte_valid) begin
            launch = LAUNCH_DATA;
        end else begin
            launch = LAUNCH_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_pend <= 1'b0;
        end else begin
            brk_pend <= brk_req || (brk_pend && (launch != LAUNCH_BREAK));
        end
    end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       byte_ready,
    input  logic [1:0] cfg_width,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    input  logic       brk_req,
    input  logic       afc_en,
    input  logic       cts_n,
    output logic       txd,
    output logic       busy,
    output logic       all_sent
);
    tx_cfg_t cfg;
    launch_e launch;
    frame_t  next_frame;
    logic    load;
    logic    bit_end;
    logic    active;
    logic    brk_pend;

    assign cfg        = '{width_code: cfg_width, par_en: cfg_par_en,
                          par_odd: cfg_par_odd, two_stop: cfg_two_stop};
    assign next_frame = build_frame(byte_data, cfg, launch == LAUNCH_BREAK);
    assign load       = (launch != LAUNCH_NONE);

    tx_launch_ctrl i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick16),
        .active     (active),
        .byte_valid (byte_valid),
        .brk_req    (brk_req),
        .afc_en     (afc_en),
        .cts_n      (cts_n),
        .byte_ready (byte_ready),
        .launch     (launch),
        .brk_pend   (brk_pend)
    );

    tx_bit_timer #(.TICKS(TICKS_PER_BIT)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .active  (active),
        .load    (load),
        .bit_end (bit_end)
    );

    tx_frame_shifter i_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .frame_in (next_frame),
        .advance  (bit_end),
        .txd      (txd),
        .active   (active)
    );

    assign busy     = active;
    assign all_sent = !active && !byte_valid && !brk_pend;
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
    input logic clk,
    input logic rst,
    input logic tick16,
    input logic byte_valid,
    input logic byte_ready,
    input logic afc_en,
    input logic cts_n,
    input logic txd,
    input logic busy,
    input logic all_sent
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    assert_edge_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (txd != $past(txd)) |-> $past(tick16));

    assert_ready_when_free_R6: assert property (@(posedge clk) disable iff (rst)
        byte_ready |-> (!busy && tick16));

    assert_cts_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (afc_en && cts_n) |-> !byte_ready);

    assert_all_sent_idle_R10: assert property (@(posedge clk) disable iff (rst)
        all_sent |-> (!busy && !byte_valid));

    assert_busy_start_tick_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(tick16));
endmodule

bind uart_tx_framer uart_tx_framer_chk i_chk (.*);

// File: tb/test_uart_tx_framer.sv
`timescale 1ns/1ps
module test_uart_tx_framer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       byte_ready;
    logic [1:0] cfg_width = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       brk_req = 1'b0;
    logic       afc_en = 1'b0;
    logic       cts_n = 1'b0;
    logic       txd;
    logic       busy;
    logic       all_sent;

    uart_tx_framer i_uart_tx_framer (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int tick_div = 2;
    int tcnt = 0;
    int accepted = 0;
    bit hold_src = 1'b0;
    bit done = 1'b0;
    logic [7:0] src_q[$];

    // reference model state
    bit mq[$];
    bit m_busy = 1'b0;
    bit m_line = 1'b1;
    bit m_pend = 1'b0;
    int m_cnt = 0;
    bit go_brk, go_dat, par;
    int w, n;
    int run_low = 0, max_low = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0; m_line = 1'b1; m_pend = 1'b0; m_cnt = 0;
            mq.delete();
            tcnt = 0;
            tick16 <= 1'b0;
            byte_valid <= 1'b0;
        end else begin
            go_brk = !m_busy && tick16 && m_pend;
            go_dat = !m_busy && tick16 && !m_pend && (!afc_en || !cts_n) && byte_valid;
            if (m_busy && tick16) begin
                if (m_cnt == 15) begin
                    m_cnt = 0;
                    if (mq.size() == 0) begin
                        m_busy = 1'b0;
                        m_line = 1'b1;
                    end else begin
                        m_line = mq.pop_front();
                    end
                end else begin
                    m_cnt++;
                end
            end else if (go_brk || go_dat) begin
                w = 5 + int'(cfg_width);
                if (go_brk) begin
                    n = 2 + w + int'(cfg_par_en) + int'(cfg_two_stop);
                    for (int i = 0; i < n; i++) mq.push_back(1'b0);
                end else begin
                    mq.push_back(1'b0);
                    par = cfg_par_odd;
                    for (int i = 0; i < w; i++) begin
                        mq.push_back(byte_data[i]);
                        par = par ^ byte_data[i];
                    end
                    if (cfg_par_en) mq.push_back(par);
                    mq.push_back(1'b1);
                    if (cfg_two_stop) mq.push_back(1'b1);
                end
                m_line = mq.pop_front();
                m_cnt = 0;
                m_busy = 1'b1;
            end
            m_pend = brk_req || (m_pend && !go_brk);
            if (go_dat) begin
                void'(src_q.pop_front());
                accepted++;
            end
            byte_valid <= (src_q.size() > 0) && !hold_src;
            byte_data  <= (src_q.size() > 0) ? src_q[0] : 8'h00;
            tcnt = (tcnt + 1) % tick_div;
            tick16 <= (tcnt == 0);
        end
    end

    // per-cycle comparison against the model
    bit exp_ready, exp_all;
    always @(negedge clk) begin
        if (!rst && !done) begin
            exp_ready = !m_busy && tick16 && !m_pend && (!afc_en || !cts_n);
            exp_all   = !m_busy && !byte_valid && !m_pend;
            checks++;
            if (txd !== m_line || busy !== m_busy || byte_ready !== exp_ready || all_sent !== exp_all) begin
                fails++;
                $display("FAIL R2 R3 R4 R5 R12 txd=%b exp %b; R11 busy=%b exp %b; R6 ready=%b exp %b; R10 all_sent=%b exp %b at %0t",
                         txd, m_line, busy, m_busy, byte_ready, exp_ready, all_sent, exp_all, $time);
            end
            if (txd === 1'b0) run_low++; else run_low = 0;
            if (run_low > max_low) max_low = run_low;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_cfg(input logic [1:0] wc, input logic pe, input logic po, input logic ts);
        @(posedge clk); #1;
        cfg_width = wc; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 30000; k++) begin
            @(negedge clk);
            if (src_q.size() == 0 && !byte_valid && !busy && !m_pend) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    int base;
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
        check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        @(posedge clk); #1 rst = 1'b0;

        // R2: 8N1, several patterns
        drive_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        src_q.push_back(8'h55); src_q.push_back(8'hA3);
        src_q.push_back(8'h00); src_q.push_back(8'hFF);
        wait_idle();
        check(accepted == 4, "R2 bytes sent 8N1", accepted, 4);

        // R3/R4: five bits even parity, six bits odd with two stops, seven even two stops
        drive_cfg(2'd0, 1'b1, 1'b0, 1'b0);
        src_q.push_back(8'h1F); src_q.push_back(8'hFA);
        wait_idle();
        check(accepted == 6, "R3 five-bit even parity frames", accepted, 6);
        tick_div = 1;
        drive_cfg(2'd1, 1'b1, 1'b1, 1'b1);
        src_q.push_back(8'h2C); src_q.push_back(8'hC0);
        wait_idle();
        check(accepted == 8, "R4 six-bit odd two-stop frames", accepted, 8);
        drive_cfg(2'd2, 1'b1, 1'b0, 1'b1);
        src_q.push_back(8'h7F);
        wait_idle();
        check(accepted == 9, "R4 seven-bit frame", accepted, 9);
        tick_div = 2;

        // R12: settings change while a frame is on the line
        drive_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        src_q.push_back(8'h96);
        for (int k = 0; k < 2000 && !busy; k++) @(negedge clk);
        repeat (60) @(negedge clk);
        drive_cfg(2'd0, 1'b1, 1'b1, 1'b1);
        wait_idle();
        check(accepted == 10, "R12 frame kept its start-time settings", accepted, 10);

        // R7/R8: break requested mid-frame, with bytes still queued
        drive_cfg(2'd3, 1'b1, 1'b0, 1'b1);
        src_q.push_back(8'h5A); src_q.push_back(8'h3C); src_q.push_back(8'hE1);
        for (int k = 0; k < 2000 && !busy; k++) @(negedge clk);
        repeat (30) @(negedge clk);
        max_low = 0;
        @(posedge clk); #1 brk_req = 1'b1;
        @(posedge clk); #1 brk_req = 1'b0;
        wait_idle();
        check(max_low == 12 * 16 * tick_div, "R7 break low length in cycles", max_low, 12 * 16 * tick_div);
        check(accepted == 13, "R8 bytes sent after break", accepted, 13);

        // R9: flow control holds back a new word, but not one in flight
        afc_en = 1'b1; cts_n = 1'b1;
        src_q.push_back(8'h81);
        repeat (600) @(negedge clk);
        check(accepted == 13, "R9 no byte taken while cts_n high", accepted, 13);
        check(busy === 1'b0, "R9 line idle while cts_n high", int'(busy), 0);
        @(posedge clk); #1 cts_n = 1'b0;
        for (int k = 0; k < 2000 && !busy; k++) @(negedge clk);
        @(posedge clk); #1 cts_n = 1'b1;
        src_q.push_back(8'h42);
        repeat (12 * 16 * 2 + 50) @(negedge clk);
        check(accepted == 14, "R9 one frame completed after cts_n rose", accepted, 14);
        check(busy === 1'b0, "R9 second byte held back", int'(busy), 0);
        @(posedge clk); #1 cts_n = 1'b0;
        wait_idle();
        check(accepted == 15, "R9 held byte sent after cts_n fell", accepted, 15);
        check(all_sent === 1'b1, "R10 all_sent at end", int'(all_sent), 1);
        check(txd === 1'b1, "R1 idle line high at end", int'(txd), 1);

        finish_run();
    end
endmodule